// File: doc/BRIEF.md
# AXI4-Lite Single-Read Sequencer

This block lets a controlling state machine run one AXI4-Lite read by raising a request line. It does not have to repeat the address-phase and data-phase states for every read it needs. The controller places an address on `req_addr` and raises `req_start`. The sequencer then performs the read on its AXI4-Lite master port, stores the returned word and response code, and raises `req_done`. The controller drops `req_start` once it sees `req_done`. The sequencer then drops `req_done` and is ready for the next request. This is a four-phase request/acknowledge exchange.

The engine has four states:

- `ST_IDLE` waits for a fresh rising edge of `req_start`.
- `ST_ADDR` drives the read-address channel and holds the read-data ready line high.
- `ST_DATA` waits for the data beat after the address has been accepted.
- `ST_DONE_WAIT` holds `req_done` until the request is withdrawn.

The transitions are:

- **accept**: `ST_IDLE`→`ST_ADDR`, on a new start edge.
- **addr_only**: `ST_ADDR`→`ST_DATA`, when the address is taken and no data has arrived yet.
- **both_done**: `ST_ADDR`→`ST_DONE_WAIT`, when the address is taken and the data is already or simultaneously captured.
- **data_in**: `ST_DATA`→`ST_DONE_WAIT`, on the data beat.
- **release**: `ST_DONE_WAIT`→`ST_IDLE`, when start is seen low.

An early data beat in `ST_ADDR` is stored and noted by an internal flag, so the engine stays in `ST_ADDR` until the address handshake completes.

Top module: `axil_read_engine`

## Requirements
- R1: One cycle after `req_start` is sampled high with the engine idle and armed, `m_arvalid` and `m_rready` are both high and `m_araddr` equals the address sampled with that start.
- R2: `m_arvalid` stays high until a clock edge samples `m_arready` high, and is low in the next cycle.
- R3: The first edge that samples `m_rvalid` and `m_rready` both high stores `m_rdata` into `rd_data`; `m_rready` is low from the next cycle until the next request.
- R4: `req_done` rises only after both the address and the data handshakes have completed. While it is high, `m_arvalid` and `m_rready` are low, and `rd_data`/`rd_resp` hold the captured beat.
- R5: `req_done` stays high while `req_start` is high. It is low in the cycle after the first edge that samples `req_start` low, and the engine is then idle.
- R6: A transaction starts only on a low-to-high change of `req_start`. A start held high across reset, or kept high after `req_done`, starts nothing.
- R7: The address is latched when the request is accepted; later changes on `req_addr` do not alter `m_araddr` for that transaction.
- R8: `m_rresp` (2 bits) is stored into `rd_resp` on the same edge as the data.
- R9: A synchronous active-low `rst_n` returns the engine to idle with `m_arvalid`, `m_rready` and `req_done` low, even in the middle of a transaction.
- R10: A data beat before or in the same cycle as the address acceptance is captured once and the transaction still completes. A `m_rvalid` presented while `m_rready` is low does not change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Request line from the controller |
| req_addr | input | ADDR_W | Read address, valid when start rises |
| req_done | output | 1 | Acknowledge to the controller |
| rd_data | output | DATA_W | Captured read word |
| rd_resp | output | 2 | Captured read response |
| m_araddr | output | ADDR_W | AXI read address |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_rdata | input | DATA_W | AXI read data |
| m_rresp | input | 2 | AXI read response |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |

## Verification
The bench sweeps every pairing of address-ready delay and data-valid delay from zero to three cycles. This includes data arriving before, with and after the address acceptance. A design that ignored an early beat would hang in the data wait, and one that took a late beat twice would overwrite the word. After every beat it presents a stray data-valid with a different word, which catches a design that keeps `m_rready` high or stores without it. It holds start high across reset and after done, and it changes the controller address mid-transaction. A level-triggered start would restart at once, and an unlatched address would change on the bus.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ADDR      = 2'd1,
        ST_DATA      = 2'd2,
        ST_DONE_WAIT = 2'd3
    } lrs_state_e;

    localparam int RESP_W = 2;

endpackage

// File: rtl/lrs_start_edge.sv
module lrs_start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic idle,
    output logic accept
);

    // Reset to 1 so that a start held high through reset is not taken as an edge.
    logic start_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b1;
        end else begin
            start_q <= start;
        end
    end

    always_comb begin
        accept = idle && start && !start_q;
    end

    AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R6

endmodule

// File: rtl/lrs_addr_latch.sv
module lrs_addr_latch #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
        end
    end

endmodule

// File: rtl/lrs_capture.sv
module lrs_capture #(
    parameter int DATA_W = 32,
    parameter int RESP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] data_in,
    input  logic [RESP_W-1:0] resp_in,
    output logic [DATA_W-1:0] data_q,
    output logic [RESP_W-1:0] resp_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            resp_q <= '0;
        end else if (cap_en) begin
            data_q <= data_in;
            resp_q <= resp_in;
        end
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(data_q) && $stable(resp_q)); // R10

endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
    import lrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       accept,
    input  logic       arready,
    input  logic       rvalid,
    output logic       idle,
    output logic       arvalid,
    output logic       rready,
    output logic       done,
    output logic       cap_en
);

    lrs_state_e state_q, state_d;
    logic       got_q, got_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            got_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            got_q   <= got_d;
        end
    end

    // Output process
    always_comb begin
        idle    = 1'b0;
        arvalid = 1'b0;
        rready  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:      idle = 1'b1;
            ST_ADDR: begin
                arvalid = 1'b1;
                rready  = !got_q;
            end
            ST_DATA:      rready = 1'b1;
            ST_DONE_WAIT: done = 1'b1;
            default:      idle = 1'b1;
        endcase
        cap_en = rvalid && rready;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        got_d   = got_q;
        unique case (state_q)
            ST_IDLE: begin
                got_d = 1'b0;
                if (accept) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (cap_en) got_d = 1'b1;
                if (arready) begin
                    if (got_q || cap_en) state_d = ST_DONE_WAIT;
                    else                 state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (cap_en) state_d = ST_DONE_WAIT;
            end
            ST_DONE_WAIT: begin
                if (!start) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_RREADY_WITH_ARVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arvalid) |-> rready); // R1
    AST_ARVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid); // R2
    AST_ARVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready |=> !arvalid); // R2
    AST_RREADY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && rready |=> !rready); // R3
    AST_NO_HS_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !arvalid && !rready); // R4
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && start |=> done); // R5
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done && idle); // R5

endmodule

// File: rtl/axil_read_engine.sv
module axil_read_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_resp,
    output logic [ADDR_W-1:0] m_araddr,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rvalid,
    output logic              m_rready
);

    localparam int RESP_W = lrs_pkg::RESP_W;

    logic idle;
    logic accept;
    logic cap_en;

    lrs_start_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (req_start),
        .idle   (idle),
        .accept (accept)
    );

    lrs_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr_in (req_addr),
        .addr_q  (m_araddr)
    );

    lrs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (req_start),
        .accept  (accept),
        .arready (m_arready),
        .rvalid  (m_rvalid),
        .idle    (idle),
        .arvalid (m_arvalid),
        .rready  (m_rready),
        .done    (req_done),
        .cap_en  (cap_en)
    );

    lrs_capture #(.DATA_W(DATA_W), .RESP_W(RESP_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .data_in (m_rdata),
        .resp_in (m_rresp),
        .data_q  (rd_data),
        .resp_q  (rd_resp)
    );

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> $stable(m_araddr)); // R7
    AST_START_HELD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        req_done && req_start |=> !m_arvalid); // R6

endmodule

// File: tb/tb_axil_read_engine.sv
`timescale 1ns/1ps
module tb_axil_read_engine;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_start;
    logic [AW-1:0] req_addr;
    logic          req_done;
    logic [DW-1:0] rd_data;
    logic [1:0]    rd_resp;
    logic [AW-1:0] m_araddr;
    logic          m_arvalid;
    logic          m_arready;
    logic [DW-1:0] m_rdata;
    logic [1:0]    m_rresp;
    logic          m_rvalid;
    logic          m_rready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    axil_read_engine #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_done(req_done), .rd_data(rd_data), .rd_resp(rd_resp),
        .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input int ar_d, input int r_d, input logic [AW-1:0] addr,
                           input logic [DW-1:0] data, input logic [1:0] resp);
        int mx;
        mx = (ar_d > r_d) ? ar_d : r_d;
        req_addr  = addr;
        req_start = 1'b1;
        @(negedge clk);
        chk("R1 araddr", m_araddr, addr);
        req_addr = ~addr; // R7: changing controller address must not matter
        for (int k = 0; k <= mx + 1; k++) begin
            chk("R2 arvalid", m_arvalid, k <= ar_d);
            chk("R3 rready", m_rready, k <= r_d);
            chk("R4 done", req_done, k > mx);
            chk("R7 addr held", m_araddr, addr);
            if (k <= mx) begin
                m_arready = (k == ar_d);
                m_rvalid  = (k == r_d) || (k == r_d + 1);
                m_rdata   = (k == r_d) ? data : ~data;
                m_rresp   = (k == r_d) ? resp : ~resp;
                @(negedge clk);
            end
        end
        m_arready = 1'b0;
        chk("R3 rd_data", rd_data, data);
        chk("R8 rd_resp", rd_resp, resp);
        // stray beat while done: R10
        m_rvalid = 1'b1; m_rdata = ~data; m_rresp = ~resp;
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            m_rvalid = 1'b0;
            chk("R5 done held", req_done, 1'b1);
            chk("R6 no restart", m_arvalid, 1'b0);
            chk("R10 data kept", rd_data, data);
            chk("R10 resp kept", rd_resp, resp);
        end
        req_start = 1'b0;
        @(negedge clk);
        chk("R5 done drops", req_done, 1'b0);
        @(negedge clk);
        chk("R5 idle", m_arvalid, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_start = 1'b1; req_addr = '0;
        m_arready = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_rresp = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset arvalid", m_arvalid, 1'b0);
        chk("R9 reset rready", m_rready, 1'b0);
        chk("R9 reset done", req_done, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R6 held start after reset", m_arvalid, 1'b0);
        end
        req_start = 1'b0;
        @(negedge clk);

        for (int a = 0; a < 4; a++) begin
            for (int r = 0; r < 4; r++) begin
                run_txn(a, r, 32'h0000_1000 + 32'((a * 4 + r) * 4),
                        32'hA500_0000 + 32'(a * 16 + r) * 32'h0001_0101,
                        2'((a + r) % 4));
            end
        end

        // R9: reset in the middle of a transaction
        req_addr = 32'hDEAD_0000; req_start = 1'b1;
        @(negedge clk);
        chk("R1 mid arvalid", m_arvalid, 1'b1);
        rst_n = 1'b0; req_start = 1'b0;
        @(negedge clk);
        chk("R9 mid arvalid", m_arvalid, 1'b0);
        chk("R9 mid rready", m_rready, 1'b0);
        chk("R9 mid done", req_done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(1, 0, 32'h0000_2000, 32'h1234_5678, 2'd2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule